// File: doc/BRIEF.md
# Serial Register-Access Slave with Download Mode

This block is a four-wire serial slave that gives a host controller read and write access to a bank of 128 byte-wide registers. The pins are a select (active low), a serial clock, a serial data input and a serial data output with its own enable. All pins are sampled by the block's system clock, which must run at least eight times faster than the serial clock. Every access is a 16-clock frame. The frame carries a 7-bit register address, then a direction bit, then a data byte. Address and data are sent least significant bit first. While the select stays low, frames follow each other with no gap.

A write of a set bit 0 to the mode-entry register switches the slave into download mode. In this mode every following byte on the serial input goes out on a valid/ready stream, along with a memory address. The address starts at a base value held in two registers and increases by one for each byte. Raising the select leaves download mode. It also abandons any frame that is not complete.

The download stream has valid/ready back-pressure, with these rules. Once a byte is offered, its data and address do not change until the receiver accepts it with ready. The serial side cannot be stalled. A byte that completes while an earlier byte is still waiting is dropped. The address counter still advances past a dropped byte, so the bytes after it keep their positions.

Top module: `spi_regif`

## Requirements
- R1: A frame is 16 rising serial-clock edges. Edges 1–7 carry address bits 0 to 6 (bit 0 first). Edge 8 carries the direction bit (0 = write, 1 = read). Edges 9–16 carry data bits 0 to 7 (bit 0 first).
- R2: Write data reaches the addressed register only on the 16th rising edge of a write frame.
- R3: In a read frame, the register byte is shifted out bit 0 first. Each bit changes only after a falling serial-clock edge. Bit 0 appears after the falling edge that follows the direction bit.
- R4: The output enable is high only during the data phase of a read while the select is low. It drops as soon as the select rises, and it stays low during write frames and in download mode.
- R5: While the select stays low, consecutive frames are decoded back to back with no deassertion between them.
- R6: If the select rises before the 16th edge, the frame is abandoned: no write takes effect and the next selection starts a new frame.
- R7: Writing register 0x7F with data bit 0 set enters download mode. The start address comes from register 0x7E (high byte) and register 0x7D (low byte).
- R8: In download mode each 8 serial bits form one byte, bit 0 first. The byte is offered with the current address, which then increases by one. The data and address are held while valid is high and ready is low. A byte that completes while one is pending is dropped, and the address still advances.
- R9: A rise of the select leaves download mode. The next selection decodes register frames again.
- R10: Reset clears all registers, the output enable and the stream valid.
- R11: The select is high whenever reset is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the host, idle low |
| csn_i | input | 1 | Select, active low |
| mosi_i | input | 1 | Serial data from the host |
| miso_o | output | 1 | Serial read data |
| miso_oe_o | output | 1 | Output enable for the serial data pad |
| dl_valid_o | output | 1 | Download byte offered |
| dl_ready_i | input | 1 | Download byte accepted |
| dl_data_o | output | 8 | Download byte |
| dl_addr_o | output | 16 | Memory address of the download byte |

## Verification
Some rules are checked by the assertions on every system clock: register writes happen only on the last edge of a frame; the output enable is confined to register mode with the select low; read data moves only after falling serial-clock edges; a waiting download byte is held stable; releasing the select clears the bit counter; and download mode makes no register writes. Other behaviours can only be shown by the bench scenarios, because they depend on values across whole frames: the bit order of address and data, the values read back after writes, aborted frames that leave registers unchanged, the base address loaded on entry to download mode, a dropped byte that still advances the address, and the return to register decoding after the select is released.

// File: rtl/spi_regif_pkg.sv
package spi_regif_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_REG  = 2'd1,
    MODE_DL   = 2'd2
  } regif_mode_e;
endpackage

// File: rtl/spi_regif_sync.sv
// Brings the three serial inputs into the system clock domain and
// derives one-cycle pulses for serial clock edges.
module spi_regif_sync #(
  parameter int N_STG = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic csn_i,
  input  logic mosi_i,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic csn_s,
  output logic mosi_s
);
  logic [N_STG:0]   sclk_pipe;
  logic [N_STG-1:0] csn_pipe;
  logic [N_STG-1:0] mosi_pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_pipe <= '0;
      csn_pipe  <= '1;
      mosi_pipe <= '0;
    end else begin
      sclk_pipe <= {sclk_pipe[N_STG-1:0], sclk_i};
      csn_pipe  <= {csn_pipe[N_STG-2:0], csn_i};
      mosi_pipe <= {mosi_pipe[N_STG-2:0], mosi_i};
    end
  end

  // mosi and select are taken from the same stage as the edge decision
  assign sclk_rise = sclk_pipe[N_STG-1] & ~sclk_pipe[N_STG];
  assign sclk_fall = ~sclk_pipe[N_STG-1] & sclk_pipe[N_STG];
  assign csn_s     = csn_pipe[N_STG-1];
  assign mosi_s    = mosi_pipe[N_STG-1];
endmodule

// File: rtl/spi_regif_bank.sv
// Byte-wide register bank: one write port, one addressed read port and a
// fixed tap that forms the download base address.
module spi_regif_bank #(
  parameter int          REG_AW  = 7,
  parameter int          DATA_W  = 8,
  parameter int          MEM_AW  = 16,
  parameter logic [6:0]  BASE_LO = 7'h7D,
  parameter logic [6:0]  BASE_HI = 7'h7E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [REG_AW-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [MEM_AW-1:0] base
);
  localparam int N_REG = 1 << REG_AW;

  logic [DATA_W-1:0]   regs [N_REG];
  logic [2*DATA_W-1:0] base_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_REG; i++) regs[i] <= '0;
    end else if (we) begin
      regs[addr] <= wdata;
    end
  end

  assign rdata     = regs[addr];
  assign base_full = {regs[REG_AW'(BASE_HI)], regs[REG_AW'(BASE_LO)]};
  assign base      = base_full[MEM_AW-1:0];
endmodule

// File: rtl/spi_regif_frame.sv
// Frame decoder: counts serial edges, assembles address and data, commits
// writes on the last edge, shifts read data out on falling edges and
// tracks the interface mode.
module spi_regif_frame
  import spi_regif_pkg::*;
#(
  parameter int         REG_AW   = 7,
  parameter int         DATA_W   = 8,
  parameter logic [6:0] ENTRY_AD = 7'h7F,
  localparam int        FRAME_N  = REG_AW + 1 + DATA_W,
  localparam int        CNT_W    = $clog2(FRAME_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              csn_s,
  input  logic              mosi_s,
  input  logic [DATA_W-1:0] rd_byte,
  output logic [REG_AW-1:0] reg_addr,
  output logic              reg_we,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              dl_enter,
  output regif_mode_e       mode,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic              miso,
  output logic              rd_act
);
  localparam logic [CNT_W-1:0] RW_POS   = CNT_W'(REG_AW);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_N - 1);

  logic [REG_AW-1:0] addr_sr;
  logic [DATA_W-2:0] dat_sr;
  logic [DATA_W-1:0] rd_sr;
  logic              rw_q;
  logic              reg_edge;

  assign reg_edge  = sclk_rise && !csn_s && (mode != MODE_DL);
  assign reg_addr  = addr_sr;
  assign reg_wdata = {mosi_s, dat_sr};
  assign reg_we    = reg_edge && (bit_cnt == LAST_POS) && !rw_q;
  assign dl_enter  = reg_we && (addr_sr == REG_AW'(ENTRY_AD)) && reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode    <= MODE_IDLE;
      bit_cnt <= '0;
      addr_sr <= '0;
      dat_sr  <= '0;
      rd_sr   <= '0;
      rw_q    <= 1'b0;
      miso    <= 1'b0;
      rd_act  <= 1'b0;
    end else if (csn_s) begin
      mode    <= MODE_IDLE;
      bit_cnt <= '0;
      rw_q    <= 1'b0;
      rd_act  <= 1'b0;
    end else begin
      if (mode == MODE_IDLE) mode <= MODE_REG;
      if (reg_edge) begin
        bit_cnt <= (bit_cnt == LAST_POS) ? '0 : bit_cnt + 1'b1;
        if (bit_cnt < RW_POS) begin
          addr_sr <= {mosi_s, addr_sr[REG_AW-1:1]};
        end else if (bit_cnt == RW_POS) begin
          rw_q <= mosi_s;
          if (mosi_s) rd_sr <= rd_byte;
        end else if (bit_cnt != LAST_POS) begin
          dat_sr <= {mosi_s, dat_sr[DATA_W-2:1]};
        end
        if (bit_cnt == LAST_POS) begin
          rw_q   <= 1'b0;
          rd_act <= 1'b0;
          if (dl_enter) mode <= MODE_DL;
        end
      end
      if (sclk_fall && rw_q && (bit_cnt > RW_POS)) begin
        miso   <= rd_sr[0];
        rd_sr  <= rd_sr >> 1;
        rd_act <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_regif_dl.sv
// Download path: assembles bytes and offers them on a valid/ready stream
// with an incrementing memory address.
module spi_regif_dl #(
  parameter int  DATA_W = 8,
  parameter int  MEM_AW = 16,
  localparam int BCNT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              enter,
  input  logic [MEM_AW-1:0] base,
  input  logic              sclk_rise,
  input  logic              mosi_s,
  input  logic              ready,
  output logic              valid,
  output logic [DATA_W-1:0] data,
  output logic [MEM_AW-1:0] addr
);
  localparam logic [BCNT_W-1:0] BYTE_LAST = BCNT_W'(DATA_W - 1);

  logic [DATA_W-2:0] byte_sr;
  logic [BCNT_W-1:0] bcnt;
  logic [MEM_AW-1:0] ptr;
  logic              byte_done;
  logic              take;

  assign byte_done = active && sclk_rise && (bcnt == BYTE_LAST);
  assign take      = valid && ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_sr <= '0;
      bcnt    <= '0;
      ptr     <= '0;
      valid   <= 1'b0;
      data    <= '0;
      addr    <= '0;
    end else begin
      if (take) valid <= 1'b0;
      if (enter) begin
        ptr  <= base;
        bcnt <= '0;
      end else if (!active) begin
        bcnt <= '0;
      end else if (sclk_rise) begin
        bcnt <= (bcnt == BYTE_LAST) ? '0 : bcnt + 1'b1;
        if (bcnt != BYTE_LAST) byte_sr <= {mosi_s, byte_sr[DATA_W-2:1]};
      end
      if (byte_done) begin
        ptr <= ptr + 1'b1;
        if (!valid || take) begin
          valid <= 1'b1;
          data  <= {mosi_s, byte_sr};
          addr  <= ptr;
        end
      end
    end
  end
endmodule

// File: rtl/spi_regif.sv
module spi_regif
  import spi_regif_pkg::*;
#(
  parameter int         REG_AW   = 7,
  parameter int         DATA_W   = 8,
  parameter int         MEM_AW   = 16,
  parameter int         N_STG    = 2,
  parameter logic [6:0] ENTRY_AD = 7'h7F,
  parameter logic [6:0] BASE_LO  = 7'h7D,
  parameter logic [6:0] BASE_HI  = 7'h7E,
  localparam int        CNT_W    = $clog2(REG_AW + 1 + DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              csn_i,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic              miso_oe_o,
  output logic              dl_valid_o,
  input  logic              dl_ready_i,
  output logic [DATA_W-1:0] dl_data_o,
  output logic [MEM_AW-1:0] dl_addr_o
);
  logic              sclk_rise, sclk_fall, csn_s, mosi_s;
  logic [REG_AW-1:0] reg_addr;
  logic              reg_we;
  logic [DATA_W-1:0] reg_wdata, rd_byte;
  logic [MEM_AW-1:0] base;
  logic              dl_enter;
  regif_mode_e       mode;
  logic [CNT_W-1:0]  bit_cnt;
  logic              rd_act;

  spi_regif_sync #(.N_STG(N_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .csn_i(csn_i), .mosi_i(mosi_i),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .csn_s(csn_s), .mosi_s(mosi_s)
  );

  spi_regif_frame #(.REG_AW(REG_AW), .DATA_W(DATA_W), .ENTRY_AD(ENTRY_AD)) u_frame (
    .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .csn_s(csn_s), .mosi_s(mosi_s), .rd_byte(rd_byte), .reg_addr(reg_addr),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .dl_enter(dl_enter), .mode(mode),
    .bit_cnt(bit_cnt), .miso(miso_o), .rd_act(rd_act)
  );

  spi_regif_bank #(.REG_AW(REG_AW), .DATA_W(DATA_W), .MEM_AW(MEM_AW),
                   .BASE_LO(BASE_LO), .BASE_HI(BASE_HI)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(rd_byte), .base(base)
  );

  spi_regif_dl #(.DATA_W(DATA_W), .MEM_AW(MEM_AW)) u_dl (
    .clk(clk), .rst_n(rst_n), .active((mode == MODE_DL) && !csn_s),
    .enter(dl_enter), .base(base), .sclk_rise(sclk_rise), .mosi_s(mosi_s),
    .ready(dl_ready_i), .valid(dl_valid_o), .data(dl_data_o), .addr(dl_addr_o)
  );

  // pad enable released directly by the raw select so the line frees at once
  assign miso_oe_o = rd_act && !csn_i;
endmodule

// File: rtl/spi_regif_chk.sv
module spi_regif_chk
  import spi_regif_pkg::*;
#(
  parameter int  DATA_W = 8,
  parameter int  MEM_AW = 16,
  parameter int  CNT_W  = 4,
  parameter int  LAST   = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              csn_i,
  input logic              csn_s,
  input logic              sclk_rise,
  input logic              sclk_fall,
  input logic              miso_o,
  input logic              miso_oe_o,
  input logic              dl_valid_o,
  input logic              dl_ready_i,
  input logic [DATA_W-1:0] dl_data_o,
  input logic [MEM_AW-1:0] dl_addr_o,
  input logic              reg_we,
  input logic [CNT_W-1:0]  bit_cnt,
  input regif_mode_e       mode
);
  assert_csn_high_in_reset_R11: assert property (@(posedge clk)
    !rst_n |-> csn_i);

  assert_write_on_last_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> (sclk_rise && bit_cnt == CNT_W'(LAST)));

  assert_oe_only_in_reg_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    miso_oe_o |-> (mode == MODE_REG && !csn_i));

  assert_miso_moves_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_fall |=> $stable(miso_o));

  assert_stream_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dl_valid_o && !dl_ready_i) |=> (dl_valid_o && $stable(dl_data_o) && $stable(dl_addr_o)));

  assert_release_clears_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    csn_s |=> (bit_cnt == '0));

  assert_no_reg_write_in_dl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_DL) |-> !reg_we);
endmodule

bind spi_regif spi_regif_chk #(
  .DATA_W(DATA_W), .MEM_AW(MEM_AW), .CNT_W(CNT_W), .LAST(REG_AW + DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .csn_i(csn_i), .csn_s(csn_s), .sclk_rise(sclk_rise),
  .sclk_fall(sclk_fall), .miso_o(miso_o), .miso_oe_o(miso_oe_o),
  .dl_valid_o(dl_valid_o), .dl_ready_i(dl_ready_i), .dl_data_o(dl_data_o),
  .dl_addr_o(dl_addr_o), .reg_we(reg_we), .bit_cnt(bit_cnt), .mode(mode)
);

// File: tb/spi_regif_tb_top.sv
`timescale 1ns/1ps
module spi_regif_tb_top;
  localparam int HALF = 6;
  localparam int NVEC = 10;
  // entry: {rw, addr[6:0], wdata[7:0], expected read[7:0]}
  localparam logic [23:0] VEC [NVEC] = '{
    {1'b0, 7'h01, 8'hA5, 8'h00},
    {1'b0, 7'h40, 8'h3C, 8'h00},
    {1'b0, 7'h7D, 8'h10, 8'h00},
    {1'b0, 7'h7E, 8'h02, 8'h00},
    {1'b0, 7'h7F, 8'hFE, 8'h00},
    {1'b1, 7'h01, 8'h00, 8'hA5},
    {1'b1, 7'h40, 8'h00, 8'h3C},
    {1'b1, 7'h02, 8'h00, 8'h00},
    {1'b1, 7'h7E, 8'h00, 8'h02},
    {1'b1, 7'h7F, 8'h00, 8'hFE}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0;
  logic csn = 1'b1;
  logic mosi = 1'b0;
  logic dl_ready = 1'b0;
  logic miso, miso_oe, dl_valid;
  logic [7:0] dl_data;
  logic [15:0] dl_addr;
  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] rd;
  logic oe_any, oe_all;

  always #2 clk = ~clk;

  spi_regif dut_i (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .csn_i(csn), .mosi_i(mosi),
    .miso_o(miso), .miso_oe_o(miso_oe), .dl_valid_o(dl_valid),
    .dl_ready_i(dl_ready), .dl_data_o(dl_data), .dl_addr_o(dl_addr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic spi_bit(input logic b, output logic so, output logic oe);
    @(negedge clk) mosi = b;
    repeat (HALF) @(negedge clk);
    so = miso;
    oe = miso_oe;
    sclk = 1'b1;
    repeat (HALF) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic select();
    @(negedge clk) csn = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic release_cs();
    @(negedge clk) csn = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  // nbits < 16 gives a truncated frame
  task automatic frame(input logic rw, input logic [6:0] a, input logic [7:0] d,
                       input int nbits, output logic [7:0] rdv,
                       output logic any, output logic all);
    logic [15:0] bits;
    logic so, oe;
    bits = {d, rw, a};
    rdv = '0; any = 1'b0; all = 1'b1;
    for (int i = 0; i < nbits; i++) begin
      spi_bit(bits[i], so, oe);
      if (i >= 8) begin
        rdv[i-8] = so;
        any = any | oe;
        all = all & oe;
      end
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    logic so, oe;
    for (int i = 0; i < 8; i++) begin
      spi_bit(b[i], so, oe);
      check("R4 oe low in download", {31'b0, oe}, 32'h0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    check("R10 oe in reset", {31'b0, miso_oe}, 0);
    check("R10 valid in reset", {31'b0, dl_valid}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 R3 R5: table walked in one selection, frames back to back
    select();
    for (int v = 0; v < NVEC; v++) begin
      frame(VEC[v][23], VEC[v][22:16], VEC[v][15:8], 16, rd, oe_any, oe_all);
      if (VEC[v][23]) begin
        check("R1 R3 R5 read data", {24'b0, rd}, {24'b0, VEC[v][7:0]});
        check("R4 oe through read data phase", {31'b0, oe_all}, 1);
      end else begin
        check("R4 oe low in write", {31'b0, oe_any}, 0);
      end
    end
    release_cs();
    check("R4 oe after release", {31'b0, miso_oe}, 0);

    // R6: write cut after 15 edges is discarded
    select();
    frame(1'b0, 7'h05, 8'hFF, 15, rd, oe_any, oe_all);
    release_cs();
    select();
    frame(1'b1, 7'h05, 8'h00, 16, rd, oe_any, oe_all);
    check("R6 aborted write ignored", {24'b0, rd}, 0);
    release_cs();

    // R4 R6: read aborted mid data, enable drops at once, count restarts
    select();
    frame(1'b1, 7'h01, 8'h00, 11, rd, oe_any, oe_all);
    check("R4 oe during partial read", {31'b0, miso_oe}, 1);
    @(negedge clk) csn = 1'b1;
    @(negedge clk);
    check("R4 oe drops on select release", {31'b0, miso_oe}, 0);
    repeat (8) @(negedge clk);
    select();
    frame(1'b1, 7'h40, 8'h00, 16, rd, oe_any, oe_all);
    check("R6 frame restarts after abort", {24'b0, rd}, 8'h3C);
    release_cs();

    // R7 R8: download mode
    select();
    frame(1'b0, 7'h7F, 8'h01, 16, rd, oe_any, oe_all);
    send_byte(8'h5A);
    repeat (2) @(negedge clk);
    check("R8 first byte valid", {31'b0, dl_valid}, 1);
    check("R8 first byte data", {24'b0, dl_data}, 8'h5A);
    check("R7 base address", {16'b0, dl_addr}, 16'h0210);
    send_byte(8'h33);
    repeat (2) @(negedge clk);
    check("R8 held data under backpressure", {24'b0, dl_data}, 8'h5A);
    check("R8 held address under backpressure", {16'b0, dl_addr}, 16'h0210);
    dl_ready = 1'b1;
    @(negedge clk) dl_ready = 1'b0;
    check("R8 valid clears on accept", {31'b0, dl_valid}, 0);
    send_byte(8'h77);
    repeat (2) @(negedge clk);
    check("R8 third byte data", {24'b0, dl_data}, 8'h77);
    check("R8 address skips dropped byte", {16'b0, dl_addr}, 16'h0212);
    dl_ready = 1'b1;
    release_cs();
    check("R8 byte accepted", {31'b0, dl_valid}, 0);

    // R9: register frames again after release
    select();
    frame(1'b1, 7'h01, 8'h00, 16, rd, oe_any, oe_all);
    check("R9 register read after download", {24'b0, rd}, 8'hA5);
    frame(1'b1, 7'h7F, 8'h00, 16, rd, oe_any, oe_all);
    check("R7 entry register stored", {24'b0, rd}, 8'h01);
    release_cs();
    check("R9 no stray download byte", {31'b0, dl_valid}, 0);

    // R10: reset clears the bank
    @(negedge clk) rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 oe in second reset", {31'b0, miso_oe}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    select();
    frame(1'b1, 7'h01, 8'h00, 16, rd, oe_any, oe_all);
    check("R10 register cleared", {24'b0, rd}, 0);
    release_cs();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule